// File: doc/BRIEF.md
# Console Register Block

This block sits on a processor's load/store bus and gives software polled and interrupt-driven access to a character source (such as a keyboard controller) and a character sink (such as a display controller). Four 16-bit registers are decoded from a 16-bit address: input status at 0xFE00, input data at 0xFE02, output status at 0xFE04 and output data at 0xFE06. Reads are combinational on the bus cycle. Any side effect of a read or write takes place at the rising clock edge that ends that cycle.

On the device side, an incoming character arrives with a one-cycle strobe. It is held in the input data register until software fetches it. While that character waits, the input is locked and further characters are dropped. Outgoing characters leave with a one-cycle strobe. The output stays busy until the display returns a done pulse. Each direction has an interrupt request. It is asserted while that direction is ready and software has set the enable bit in the matching status register.

Top module: `console_mmio`

## Requirements
- R1: After reset, input status reads 0x0000, output status reads 0x8000, input data and output data read 0x0000, and both interrupt requests are low.
- R2: A `kb_strobe` while input ready is 0 latches `kb_char` into bits 7:0 of input data (0xFE02) and sets input ready (bit 15 of 0xFE00) at that clock edge.
- R3: While input ready is 1, `kb_strobe` is ignored: the input data register keeps the earlier character.
- R4: A bus read of 0xFE02 returns the held character and clears input ready at the edge ending the read. The next strobe is then accepted.
- R5: A write to 0xFE06 while output ready is 1 stores bits 7:0 of the write data in `disp_char`. At the same edge it clears output ready (bit 15 of 0xFE04) and raises `disp_strobe` for exactly one cycle.
- R6: A `disp_done` pulse while output ready is 0 sets output ready at that edge.
- R7: A write to 0xFE06 while output ready is 0 is ignored: no strobe is issued and `disp_char` is unchanged.
- R8: Bit 14 of each status register is a writable interrupt enable. `kb_irq` equals input ready AND input enable. `disp_irq` equals output ready AND output enable.
- R9: Data bits 15:8 and status bits 13:0 read as zero. Bus writes to the ready bits (bit 15) have no effect on them.
- R10: `bus_rdata` is zero when `bus_rd` is low. It is also zero for any address outside the four registers, including the odd addresses inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address from the processor |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as `bus_rd` |
| kb_char | input | 8 | Character from the input device |
| kb_strobe | input | 1 | One-cycle pulse: `kb_char` is valid |
| disp_char | output | 8 | Character to the output device |
| disp_strobe | output | 1 | One-cycle pulse: `disp_char` is new |
| disp_done | input | 1 | Output device has finished the last character |
| kb_irq | output | 1 | Input interrupt request |
| disp_irq | output | 1 | Output interrupt request |

## Verification
The bench sends a second character while the first is still waiting. A design without the input lock would overwrite the pending character, and the later read would return the wrong code. It also writes to the output data register while the display is busy. A design that accepted that write would emit an extra strobe and replace `disp_char` before the display had finished. Writes of all ones to the status registers check that ready bits cannot be forced by software. Reads at odd and out-of-window addresses catch a decoder that ignores alignment or wraps around.

// File: rtl/console_mmio_pkg.sv
package console_mmio_pkg;

   typedef enum logic [1:0] {
      SEL_IN_STAT  = 2'd0,
      SEL_IN_DATA  = 2'd1,
      SEL_OUT_STAT = 2'd2,
      SEL_OUT_DATA = 2'd3
   } cm_sel_e;

   typedef struct packed {
      logic    hit;
      cm_sel_e sel;
   } cm_dec_t;

endpackage

// File: rtl/cm_addr_decode.sv
module cm_addr_decode
   import console_mmio_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned BASE_ADDR    = 'hFE00,
   parameter int unsigned STRIDE_LOG2  = 1,
   parameter bit          STRICT_ALIGN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output cm_dec_t           dec
);
   localparam int unsigned SPAN = 4 << STRIDE_LOG2;
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(SPAN);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << STRIDE_LOG2) - 1);

   if (STRIDE_LOG2 < 1) begin : g_bad_stride
      $error("cm_addr_decode: STRIDE_LOG2 must be at least 1");
   end

   logic [ADDR_W-1:0] offset;
   logic              in_window;
   logic              aligned;

   assign offset    = addr - BASE_V;
   assign in_window = (offset < SPAN_V);

   if (STRICT_ALIGN) begin : g_strict
      assign aligned = ((offset & LOW_MASK) == '0);
   end else begin : g_loose
      assign aligned = 1'b1;
   end

   assign dec.hit = in_window && aligned;
   assign dec.sel = cm_sel_e'(offset[STRIDE_LOG2 +: 2]);
endmodule

// File: rtl/cm_input_port.sv
module cm_input_port #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAR_W-1:0] dev_char,
   input  logic              dev_stb,
   input  logic              take,
   input  logic              ien_wr,
   input  logic              ien_val,
   output logic              ready,
   output logic              ien,
   output logic [CHAR_W-1:0] char_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready  <= 1'b0;
         char_q <= '0;
      end else if (ready) begin
         if (take) ready <= 1'b0;
      end else if (dev_stb) begin
         ready  <= 1'b1;
         char_q <= dev_char;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ien <= 1'b0;
      else if (ien_wr) ien <= ien_val;
   end
endmodule

// File: rtl/cm_output_port.sv
module cm_output_port #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              put,
   input  logic [CHAR_W-1:0] put_char,
   input  logic              done,
   input  logic              ien_wr,
   input  logic              ien_val,
   output logic              ready,
   output logic              ien,
   output logic [CHAR_W-1:0] char_q,
   output logic              strobe
);
   logic launch;
   assign launch = put && ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready  <= 1'b1;
         char_q <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= launch;
         if (launch) begin
            ready  <= 1'b0;
            char_q <= put_char;
         end else if (!ready && done) begin
            ready  <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ien <= 1'b0;
      else if (ien_wr) ien <= ien_val;
   end
endmodule

// File: rtl/console_mmio.sv
module console_mmio
   import console_mmio_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned CHAR_W       = 8,
   parameter int unsigned BASE_ADDR    = 'hFE00,
   parameter int unsigned STRIDE_LOG2  = 1,
   parameter bit          STRICT_ALIGN = 1'b1,
   parameter int unsigned READY_BIT    = 15,
   parameter int unsigned IEN_BIT      = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CHAR_W-1:0] kb_char,
   input  logic              kb_strobe,
   output logic [CHAR_W-1:0] disp_char,
   output logic              disp_strobe,
   input  logic              disp_done,
   output logic              kb_irq,
   output logic              disp_irq
);
   if (CHAR_W > DATA_W) begin : g_bad_char
      $error("console_mmio: CHAR_W exceeds DATA_W");
   end
   if (READY_BIT >= DATA_W || IEN_BIT >= DATA_W) begin : g_bad_bits
      $error("console_mmio: status bit outside data width");
   end
   if (READY_BIT == IEN_BIT) begin : g_same_bits
      $error("console_mmio: ready and enable bits collide");
   end
   if (READY_BIT < CHAR_W || IEN_BIT < CHAR_W) begin : g_overlap
      $error("console_mmio: status bits overlap the character field");
   end

   cm_dec_t dec;
   logic    in_ready, in_ien, out_ready, out_ien;
   logic [CHAR_W-1:0] in_char;
   logic    rd_in_data, wr_in_stat, wr_out_stat, wr_out_data;

   cm_addr_decode #(
      .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
      .STRIDE_LOG2(STRIDE_LOG2), .STRICT_ALIGN(STRICT_ALIGN)
   ) i_dec (
      .addr(bus_addr), .dec(dec)
   );

   assign rd_in_data  = bus_rd && dec.hit && (dec.sel == SEL_IN_DATA);
   assign wr_in_stat  = bus_wr && dec.hit && (dec.sel == SEL_IN_STAT);
   assign wr_out_stat = bus_wr && dec.hit && (dec.sel == SEL_OUT_STAT);
   assign wr_out_data = bus_wr && dec.hit && (dec.sel == SEL_OUT_DATA);

   cm_input_port #(.CHAR_W(CHAR_W)) i_in (
      .clk(clk), .rst_n(rst_n),
      .dev_char(kb_char), .dev_stb(kb_strobe),
      .take(rd_in_data),
      .ien_wr(wr_in_stat), .ien_val(bus_wdata[IEN_BIT]),
      .ready(in_ready), .ien(in_ien), .char_q(in_char)
   );

   cm_output_port #(.CHAR_W(CHAR_W)) i_out (
      .clk(clk), .rst_n(rst_n),
      .put(wr_out_data), .put_char(bus_wdata[CHAR_W-1:0]),
      .done(disp_done),
      .ien_wr(wr_out_stat), .ien_val(bus_wdata[IEN_BIT]),
      .ready(out_ready), .ien(out_ien), .char_q(disp_char),
      .strobe(disp_strobe)
   );

   assign kb_irq   = in_ready && in_ien;
   assign disp_irq = out_ready && out_ien;

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && dec.hit) begin
         unique case (dec.sel)
            SEL_IN_STAT: begin
               bus_rdata[READY_BIT] = in_ready;
               bus_rdata[IEN_BIT]   = in_ien;
            end
            SEL_IN_DATA:  bus_rdata[CHAR_W-1:0] = in_char;
            SEL_OUT_STAT: begin
               bus_rdata[READY_BIT] = out_ready;
               bus_rdata[IEN_BIT]   = out_ien;
            end
            SEL_OUT_DATA: bus_rdata[CHAR_W-1:0] = disp_char;
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CHAR_W      = 8,
   parameter int unsigned BASE_ADDR   = 'hFE00,
   parameter int unsigned STRIDE_LOG2 = 1,
   parameter int unsigned READY_BIT   = 15,
   parameter int unsigned IEN_BIT     = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              kb_strobe,
   input logic [CHAR_W-1:0] disp_char,
   input logic              disp_strobe,
   input logic              disp_done,
   input logic              kb_irq,
   input logic              disp_irq,
   input logic              in_ready,
   input logic              out_ready,
   input logic [CHAR_W-1:0] in_char
);
   localparam logic [ADDR_W-1:0] A_IN_STAT  = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] A_IN_DATA  = ADDR_W'(BASE_ADDR + (1 << STRIDE_LOG2));
   localparam logic [ADDR_W-1:0] A_OUT_DATA = ADDR_W'(BASE_ADDR + 3 * (1 << STRIDE_LOG2));

   // R3: a waiting character is held until the data register is read
   p_hold_char_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !(bus_rd && bus_addr == A_IN_DATA)) |=> (in_ready && $stable(in_char)));

   // R4: reading input data drops input ready
   p_take_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && bus_rd && bus_addr == A_IN_DATA) |=> !in_ready);

   // R5: accepted write launches the character and drops ready
   p_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_OUT_DATA && out_ready) |=>
      (disp_strobe && !out_ready && disp_char == $past(bus_wdata[CHAR_W-1:0])));

   // R5: strobe is a single cycle wide
   p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      disp_strobe |=> !disp_strobe);

   // R6: done while busy restores ready
   p_done_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_ready && disp_done && !bus_wr) |=> out_ready);

   // R7: no strobe without an accepted write
   p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == A_OUT_DATA && out_ready) |=> !disp_strobe);

   // R8: interrupt agrees with the status bits seen by software
   p_kb_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_IN_STAT) |->
      (kb_irq == (bus_rdata[READY_BIT] && bus_rdata[IEN_BIT])));

   // R10: idle bus returns zero
   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));
endmodule

bind console_mmio console_mmio_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
   .BASE_ADDR(BASE_ADDR), .STRIDE_LOG2(STRIDE_LOG2),
   .READY_BIT(READY_BIT), .IEN_BIT(IEN_BIT)
) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
   .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .kb_strobe(kb_strobe), .disp_char(disp_char), .disp_strobe(disp_strobe),
   .disp_done(disp_done), .kb_irq(kb_irq), .disp_irq(disp_irq),
   .in_ready(in_ready), .out_ready(out_ready), .in_char(in_char)
);

// File: tb/test_console_mmio.sv
`timescale 1ns/1ps
module test_console_mmio;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [7:0]  kb_char = '0;
   logic        kb_strobe = 1'b0;
   logic [7:0]  disp_char;
   logic        disp_strobe, disp_done = 1'b0;
   logic        kb_irq, disp_irq;

   int errors = 0;
   int checks = 0;
   logic stb_seen;

   always #2.5 clk = ~clk;

   console_mmio i_console_mmio (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .kb_char(kb_char), .kb_strobe(kb_strobe), .disp_char(disp_char),
      .disp_strobe(disp_strobe), .disp_done(disp_done),
      .kb_irq(kb_irq), .disp_irq(disp_irq)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [15:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [15:0] a, input logic [15:0] exp);
      logic [15:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      stb_seen = disp_strobe;
   endtask

   task automatic kb_push(input logic [7:0] c);
      @(negedge clk);
      kb_char = c; kb_strobe = 1'b1;
      @(negedge clk);
      kb_strobe = 1'b0;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      disp_done = 1'b1;
      @(negedge clk);
      disp_done = 1'b0;
   endtask

   task automatic t_reset();
      rd_chk("R1 in status", 16'hFE00, 16'h0000);
      rd_chk("R1 out status", 16'hFE04, 16'h8000);
      rd_chk("R1 in data", 16'hFE02, 16'h0000);
      rd_chk("R1 out data", 16'hFE06, 16'h0000);
      chk("R1 kb_irq", {15'b0, kb_irq}, 16'h0);
      chk("R1 disp_irq", {15'b0, disp_irq}, 16'h0);
   endtask

   task automatic t_input();
      kb_push(8'h41);
      rd_chk("R2 ready set", 16'hFE00, 16'h8000);
      rd_chk("R2 char latched", 16'hFE02, 16'h0041);
      rd_chk("R4 ready cleared", 16'hFE00, 16'h0000);
      kb_push(8'h42);
      kb_push(8'h43);
      rd_chk("R3 locked char kept", 16'hFE02, 16'h0042);
      kb_push(8'h44);
      rd_chk("R4 accepted after read", 16'hFE02, 16'h0044);
   endtask

   task automatic t_output();
      wr(16'hFE06, 16'h1255);
      chk("R5 strobe", {15'b0, stb_seen}, 16'h1);
      chk("R5 disp_char", {8'h0, disp_char}, 16'h0055);
      @(negedge clk);
      chk("R5 strobe one cycle", {15'b0, disp_strobe}, 16'h0);
      rd_chk("R5 busy", 16'hFE04, 16'h0000);
      wr(16'hFE06, 16'h0066);
      chk("R7 no strobe", {15'b0, stb_seen}, 16'h0);
      chk("R7 char kept", {8'h0, disp_char}, 16'h0055);
      rd_chk("R9 upper zero", 16'hFE06, 16'h0055);
      done_pulse();
      rd_chk("R6 ready again", 16'hFE04, 16'h8000);
   endtask

   task automatic t_irq();
      logic [15:0] d;
      wr(16'hFE00, 16'hFFFF);
      rd_chk("R9 in status write", 16'hFE00, 16'h4000);
      chk("R8 kb_irq off", {15'b0, kb_irq}, 16'h0);
      kb_push(8'h5A);
      chk("R8 kb_irq on", {15'b0, kb_irq}, 16'h1);
      rd_chk("R8 in status", 16'hFE00, 16'hC000);
      rd(16'hFE02, d);
      chk("R8 kb_irq cleared", {15'b0, kb_irq}, 16'h0);
      wr(16'hFE04, 16'h7FFF);
      rd_chk("R9 out status", 16'hFE04, 16'hC000);
      chk("R8 disp_irq on", {15'b0, disp_irq}, 16'h1);
      wr(16'hFE06, 16'h0021);
      chk("R8 disp_irq busy", {15'b0, disp_irq}, 16'h0);
      done_pulse();
      chk("R8 disp_irq done", {15'b0, disp_irq}, 16'h1);
      wr(16'hFE04, 16'h0000);
      rd_chk("R9 ready not writable", 16'hFE04, 16'h8000);
      chk("R8 disp_irq disabled", {15'b0, disp_irq}, 16'h0);
   endtask

   task automatic t_unmapped();
      kb_push(8'h33);
      rd_chk("R10 above window", 16'hFE08, 16'h0000);
      rd_chk("R10 odd address", 16'hFE03, 16'h0000);
      rd_chk("R10 below window", 16'h0002, 16'h0000);
      @(negedge clk);
      bus_addr = 16'hFE00; bus_rd = 1'b0;
      #1 chk("R10 idle rdata", bus_rdata, 16'h0000);
      rd_chk("R10 in data intact", 16'hFE02, 16'h0033);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_input();
      t_output();
      t_irq();
      t_unmapped();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #50000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule